// File: doc/BRIEF.md
# Masked Interrupt Event Controller

This block gathers single-bit interrupt requests from three device sources and turns them into one CPU interrupt line. Whenever a source line changes in either direction, the controller records a sticky event bit for that source and mirrors the new line level. Recording happens only while a mode bit in the mask register is on. After each recorded change, the whole event register is filtered through the mask. The CPU interrupt stays high while any event bit is set.

Software reaches the block over a simple single-cycle register bus. It can read the mask, level and event registers, write the mask, and write a clear register. The clear register either wipes every event bit or keeps only the bits written as one. All bus data is byte-reversed between the bus and the internal registers.

Top module: `irq_event_ctrl`

## Requirements
- R1: After reset the mask, level and event registers read as zero and `irq_o` is low.
- R2: Register offsets on `bus_addr` are: events 0x00, mask 0x04, clear 0x08, levels 0x0C. A read (`bus_sel`=1, `bus_we`=0) returns the addressed register with its four bytes reversed, combinationally in the same cycle. A write to 0x04 stores the byte-reversed `bus_wdata` as the mask. `bus_rdata` is zero whenever no read is in progress.
- R3: The mode bit is bit 31 of the stored mask. While it is zero, source line changes alter neither the event register nor the level register.
- R4: The source positions are: `src_i[0]` at bit 18, `src_i[1]` at bit 12, `src_i[2]` at bit 19. With mode on, a change of a source line (either edge, found against the value of the previous clock) ORs its bit into the events. The result is then ANDed with the mask held before that clock edge. Event bits stay set after the line returns.
- R5: With mode on, a source change sets that source's level bit when the new line value is one and clears it when the new value is zero.
- R6: A write to 0x08 whose byte-reversed data has bit 31 set makes the event register zero.
- R7: A write to 0x08 whose byte-reversed data has bit 31 clear replaces the events with their AND with the byte-reversed data.
- R8: `irq_o` is a register that takes the value (events != 0) on every clock. It follows a change of the events one cycle later.
- R9: Reads of any offset other than 0x00, 0x04 and 0x0C return zero, the clear offset included. Writes to offsets other than 0x04 and 0x08 change nothing.
- R10: Writing the mask does not re-filter the events by itself. The events change only on a source change or a clear write.
- R11: Several sources changing in one cycle are all merged in that cycle. When a clear write and a source change fall in the same cycle, the clear is applied first and the change is merged into the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 3 | Device interrupt request lines |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, byte-reversed order |
| bus_rdata | output | 32 | Read data, byte-reversed order |
| irq_o | output | 1 | CPU interrupt request |

## Verification
A wrong event or level bit becomes visible on the next bus read of that register. The same cycle's read data shows the state updated at the previous edge. A wrong event register also shows on `irq_o` one cycle after the faulty update. A missed or spurious edge detection therefore shows within two cycles of the line change. A mask that was not swapped, or a mode bit taken from the wrong position, shows at once on a mask read-back. It also shows as events that fail to appear, or appear when they should not, after the next source toggle.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int REG_W       = 32;
  localparam int POS_W       = $clog2(REG_W);
  localparam int MODE_BIT    = 31;
  localparam int CLR_ALL_BIT = 31;

  typedef enum logic [1:0] {
    REG_EVENTS = 2'd0,
    REG_MASK   = 2'd1,
    REG_CLEAR  = 2'd2,
    REG_LEVELS = 2'd3
  } reg_sel_e;

  function automatic logic [REG_W-1:0] bswap32(input logic [REG_W-1:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction
endpackage

// File: rtl/irq_src_tracker.sv
module irq_src_tracker
  import irq_evt_pkg::*;
#(
  parameter int                     NUM_SRC = 3,
  parameter logic [NUM_SRC*POS_W-1:0] SRC_POS = {5'd19, 5'd12, 5'd18}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [REG_W-1:0]   chg_vec_o,
  output logic [REG_W-1:0]   lvl_vec_o,
  output logic               any_chg_o
);
  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] src_d;

  // one flop per source line, kept as a previous-cycle copy
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_comb src_d[g] = src_i[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q[g] <= 1'b0;
      else        src_q[g] <= src_d[g];
    end
  end

  // spread per-source flags onto their register bit positions
  always_comb begin
    chg_vec_o = '0;
    lvl_vec_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      chg_vec_o[SRC_POS[i*POS_W +: POS_W]] = src_i[i] ^ src_q[i];
      lvl_vec_o[SRC_POS[i*POS_W +: POS_W]] = src_i[i];
    end
    any_chg_o = |(src_i ^ src_q);
  end
endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port
  import irq_evt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [REG_W-1:0]  events_q,
  input  logic [REG_W-1:0]  mask_q,
  input  logic [REG_W-1:0]  levels_q,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              mask_we,
  output logic              clr_we,
  output logic [REG_W-1:0]  wdata_sw
);
  localparam int HI_W = ADDR_W - 4;

  logic     hit;
  reg_sel_e idx;

  always_comb begin
    hit      = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:4] == HI_W'(0));
    idx      = reg_sel_e'(bus_addr[3:2]);
    wdata_sw = bswap32(bus_wdata);
    mask_we  = bus_sel && bus_we && hit && (idx == REG_MASK);
    clr_we   = bus_sel && bus_we && hit && (idx == REG_CLEAR);
    bus_rdata = '0;
    if (bus_sel && !bus_we && hit) begin
      unique case (idx)
        REG_EVENTS: bus_rdata = bswap32(events_q);
        REG_MASK:   bus_rdata = bswap32(mask_q);
        REG_LEVELS: bus_rdata = bswap32(levels_q);
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
  import irq_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] chg_vec,
  input  logic [REG_W-1:0] lvl_vec,
  input  logic             any_chg,
  input  logic             mask_we,
  input  logic             clr_we,
  input  logic [REG_W-1:0] wdata_sw,
  output logic [REG_W-1:0] events_q,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] levels_q,
  output logic             irq_o
);
  logic [REG_W-1:0] events_d, mask_d, levels_d, ev_cleared;
  logic             mode, proc, irq_d;

  always_comb begin
    mode = mask_q[MODE_BIT];
    proc = mode && any_chg;

    ev_cleared = events_q;
    if (clr_we) begin
      if (wdata_sw[CLR_ALL_BIT]) ev_cleared = '0;
      else                       ev_cleared = events_q & wdata_sw;
    end

    events_d = ev_cleared;
    levels_d = levels_q;
    if (proc) begin
      events_d = (ev_cleared | chg_vec) & mask_q;
      levels_d = (levels_q & ~chg_vec) | (lvl_vec & chg_vec);
    end

    mask_d = mask_we ? wdata_sw : mask_q;
    irq_d  = (events_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      events_q <= '0;
      mask_q   <= '0;
      levels_q <= '0;
      irq_o    <= 1'b0;
    end else begin
      events_q <= events_d;
      levels_q <= levels_d;
      irq_o    <= irq_d;
      if (mask_we) mask_q <= mask_d;
    end
  end

  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !clr_we) |=> ($stable(events_q) && $stable(levels_q)));

  assert_filter_R4: assert property (@(posedge clk) disable iff (!rst_n)
    proc |=> ((events_q & ~$past(mask_q)) == '0));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && !proc) |=> $stable(events_q));

  assert_clrall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && wdata_sw[CLR_ALL_BIT] && !proc) |=> (events_q == '0));

  assert_maskwr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (bswap32(mask_q) == $past(bswap32(wdata_sw))));

  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == ($past(events_q) != '0)));

  assert_no_refilter_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && !any_chg) |=> $stable(events_q));
endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
  import irq_evt_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_SRC = 3,
  parameter logic [NUM_SRC*POS_W-1:0] SRC_POS = {5'd19, 5'd12, 5'd18}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               irq_o
);
  logic [REG_W-1:0] chg_vec, lvl_vec, wdata_sw;
  logic [REG_W-1:0] events_q, mask_q, levels_q;
  logic             any_chg, mask_we, clr_we;

  irq_src_tracker #(.NUM_SRC(NUM_SRC), .SRC_POS(SRC_POS)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .chg_vec_o (chg_vec),
    .lvl_vec_o (lvl_vec),
    .any_chg_o (any_chg)
  );

  irq_bus_port #(.ADDR_W(ADDR_W)) u_bus (
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .events_q  (events_q),
    .mask_q    (mask_q),
    .levels_q  (levels_q),
    .bus_rdata (bus_rdata),
    .mask_we   (mask_we),
    .clr_we    (clr_we),
    .wdata_sw  (wdata_sw)
  );

  irq_state_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .chg_vec  (chg_vec),
    .lvl_vec  (lvl_vec),
    .any_chg  (any_chg),
    .mask_we  (mask_we),
    .clr_we   (clr_we),
    .wdata_sw (wdata_sw),
    .events_q (events_q),
    .mask_q   (mask_q),
    .levels_q (levels_q),
    .irq_o    (irq_o)
  );

  assert_unmapped_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && (bus_addr[1:0] != 2'b00)) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_irq_event_ctrl.sv
module tb_irq_event_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  src_i;
  logic        bus_sel, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_mask, m_lev, m_evt, last_rd;
  logic [2:0]  m_src;
  logic        m_irq;

  irq_event_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] sw(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [31:0] spread(input logic [2:0] v);
    logic [31:0] r = '0;
    r[18] = v[0]; r[12] = v[1]; r[19] = v[2];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic s, input logic w, input logic [7:0] a);
    if (!s || w) return 32'h0;
    case (a)
      8'h00:   return sw(m_evt);
      8'h04:   return sw(m_mask);
      8'h0C:   return sw(m_lev);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic [2:0] s, input logic sel, input logic we,
                      input logic [7:0] a, input logic [31:0] d, input string tag);
    logic [31:0] chg, dsw, ev;
    @(negedge clk);
    check("R8 irq", {31'b0, irq_o}, {31'b0, m_irq});
    src_i = s; bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
    last_rd = bus_rdata;
    check(tag, bus_rdata, exp_rd(sel, we, a));
    @(posedge clk);
    m_irq = (m_evt != 0);
    chg = spread(s ^ m_src);
    dsw = sw(d);
    ev  = m_evt;
    if (sel && we && a == 8'h08) ev = dsw[31] ? 32'h0 : (m_evt & dsw);
    if (m_mask[31] && chg != 0) begin
      ev    = (ev | chg) & m_mask;
      m_lev = (m_lev & ~chg) | (spread(s) & chg);
    end
    m_evt = ev;
    if (sel && we && a == 8'h04) m_mask = dsw;
    m_src = s;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    tick(m_src, 1'b1, 1'b0, a, 32'h0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    tick(m_src, 1'b1, 1'b1, a, d, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1357);
    rst_n = 1'b0; src_i = '0; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    m_mask = 0; m_lev = 0; m_evt = 0; m_src = 0; m_irq = 0; last_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, "R1 events"); check("R1 events lit", last_rd, 32'h0);
    rd(8'h04, "R1 mask");   check("R1 mask lit", last_rd, 32'h0);
    rd(8'h0C, "R1 levels"); check("R1 levels lit", last_rd, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);

    // R2 mask write / read with byte reversal: mask 0x800C1000
    wr(8'h04, 32'h00100C80, "R2 wr");
    rd(8'h04, "R2 mask"); check("R2 mask lit", last_rd, 32'h00100C80);

    // R4 / R5 rising source 0 -> bit 18
    tick(3'b001, 0, 0, 8'h00, 0, "R4 idle");
    rd(8'h00, "R4 events"); check("R4 events lit", last_rd, 32'h00000400);
    rd(8'h0C, "R5 levels"); check("R5 levels lit", last_rd, 32'h00000400);
    check("R8 irq high", {31'b0, irq_o}, 32'h1);
    tick(3'b000, 0, 0, 8'h00, 0, "R5 idle");
    rd(8'h0C, "R5 levels low"); check("R5 levels low lit", last_rd, 32'h0);
    rd(8'h00, "R4 sticky");     check("R4 sticky lit", last_rd, 32'h00000400);

    // R11 two sources at once (bits 12, 19)
    tick(3'b110, 0, 0, 8'h00, 0, "R11 idle");
    rd(8'h00, "R11 merge"); check("R11 merge lit", last_rd, 32'h00100C00);

    // R7 partial clear keeps bit 18 only
    wr(8'h08, 32'h00000400, "R7 wr");
    rd(8'h00, "R7 events"); check("R7 events lit", last_rd, 32'h00000400);

    // R10 mask narrowing does not re-filter events
    wr(8'h04, 32'h00000080, "R10 wr");
    rd(8'h00, "R10 events"); check("R10 events lit", last_rd, 32'h00000400);
    wr(8'h04, 32'h00100C80, "R10 restore");

    // R6 clear all, irq drops one cycle later
    wr(8'h08, 32'h00000080, "R6 wr");
    rd(8'h00, "R6 events"); check("R6 events lit", last_rd, 32'h0);
    rd(8'h00, "R8 settle");
    check("R8 irq low", {31'b0, irq_o}, 32'h0);

    // R3 mode off: changes ignored
    wr(8'h04, 32'h00100C00, "R3 wr");
    tick(3'b001, 0, 0, 8'h00, 0, "R3 idle");
    rd(8'h00, "R3 events"); check("R3 events lit", last_rd, 32'h0);
    rd(8'h0C, "R3 levels"); check("R3 levels lit", last_rd, 32'h00100800);

    // R11 clear-all and change in the same cycle
    wr(8'h04, 32'h00100C80, "R11 mode");
    tick(3'b000, 1, 1, 8'h08, 32'h00000080, "R11 wr");
    rd(8'h00, "R11 same cycle"); check("R11 same cycle lit", last_rd, 32'h00000400);

    // R9 unmapped
    wr(8'h10, 32'hFFFFFFFF, "R9 wr");
    wr(8'h06, 32'h00000000, "R9 wr2");
    rd(8'h04, "R9 mask kept"); check("R9 mask kept lit", last_rd, 32'h00100C80);
    rd(8'h08, "R9 clear rd");  check("R9 clear rd lit", last_rd, 32'h0);
    rd(8'h11, "R9 odd rd");    check("R9 odd rd lit", last_rd, 32'h0);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0]  s;
      logic [31:0] v;
      int          op;
      s  = m_src ^ ((($urandom % 4) == 0) ? 3'($urandom % 8) : 3'b000);
      op = int'($urandom % 6);
      case (op)
        0: tick(s, 1, 0, 8'(($urandom % 4) * 4), 0, "R2 rand rd");
        1: tick(s, 1, 0, 8'($urandom), 0, "R9 rand rd");
        2: begin
          v = ($urandom & 32'h800C1000) | ((($urandom % 4) != 0) ? 32'h80000000 : 32'h0);
          tick(s, 1, 1, 8'h04, sw(v), "R2 rand mask");
        end
        3: begin
          v = ($urandom & 32'h7FFFFFFF) | ((($urandom % 8) == 0) ? 32'h80000000 : 32'h0);
          tick(s, 1, 1, 8'h08, sw(v), "R7 rand clr");
        end
        4: tick(s, 1, 1, 8'(8'h10 + ($urandom % 8'hE0)), $urandom, "R9 rand wr");
        default: tick(s, 0, 0, 8'h00, 0, "R4 rand idle");
      endcase
    end
    rd(8'h00, "R4 final events");
    rd(8'h04, "R2 final mask");
    rd(8'h0C, "R5 final levels");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule